// File: doc/BRIEF.md
# Floating-Point Architectural State Unit

This block keeps the architectural floating-point state of an in-order integer core that carries single- and double-precision support. It holds a bank of 32 floating-point registers, each FLEN bits wide and cleared by reset. The bank has two combinational read ports and one write port that commits on the clock edge.

It also holds an 8-bit control image. The low five bits are the sticky exception flags and bits 7:5 are the rounding mode. Software reaches this image through three aliased CSR numbers: one sees only the flags, one sees only the rounding mode, and one sees both. An execution pipeline can OR freshly raised exception flags into the image through a strobed input.

Any change to floating-point state raises a one-cycle update strobe and drives the context-status outputs to Dirty. The status outputs are a 2-bit status field and a 1-bit summary bit, and the core folds them into its own machine status register.

Top module: `fp_state_unit`

## Requirements
- R1: After reset every register reads zero, the control image reads zero, `ctx_fs` is 2'b00 and `ctx_sd` is 0.
- R2: Register reads are combinational from the bank. A write to an index in the same cycle as a read of that index returns the old value on the read, and the new value is visible from the next cycle on.
- R3: A register write raises `ctx_upd` in its own cycle. From the following cycle on, `ctx_fs` is 2'b11 (Dirty) and `ctx_sd` is 1, and both stay there until reset.
- R4: The control image holds the flags in bits 4:0 and the rounding mode in bits 7:5. Reads behave as follows:
  - address 0x001 returns the flags in bits 4:0;
  - address 0x002 returns the rounding mode in bits 2:0;
  - address 0x003 returns the whole image in bits 7:0.
  All other bits read zero. Any other address reads zero with `csr_hit` low.
- R5: A CSR write takes effect at the clock edge. At 0x001 it loads wdata[4:0] into the flags. At 0x002 it loads wdata[2:0] into the rounding mode. At 0x003 it loads wdata[7:0] into the whole image. The other field and the upper write bits are left unused, and writes to any other address change nothing.
- R6: Rounding-mode values 3'b101, 3'b110 and 3'b111 are stored and read back exactly as written.
- R7: A CSR write to 0x001, 0x002 or 0x003 raises `ctx_upd` and leaves the context Dirty. A write to any other address does neither.
- R8: During a write to 0x003, `csr_wr_result` shows the image that the edge will store, zero-extended to XLEN bits. In every other cycle it is zero.
- R9: When `acc_valid` is high, `acc_flags` is ORed into the flags at the edge and `ctx_upd` is raised. If a CSR write in the same cycle also loads the flags, the OR is applied on top of the written value.
- R10: A register write and a CSR write in the same cycle both take effect and produce a single `ctx_upd` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_ra_idx | input | 5 | Read port A index |
| rf_ra_data | output | FLEN | Read port A data |
| rf_rb_idx | input | 5 | Read port B index |
| rf_rb_data | output | FLEN | Read port B data |
| rf_we | input | 1 | Register write enable |
| rf_wr_idx | input | 5 | Register write index |
| rf_wr_data | input | FLEN | Register write data |
| csr_addr | input | 12 | CSR number |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read view, zero-extended |
| csr_hit | output | 1 | Address is one of the three aliases |
| csr_wr_result | output | XLEN | Stored image during a full-alias write |
| acc_valid | input | 1 | Exception flag accrual strobe |
| acc_flags | input | 5 | Flags to OR into the image |
| ctx_upd | output | 1 | State changed this cycle |
| ctx_fs | output | 2 | Context status field (2'b11 = Dirty) |
| ctx_sd | output | 1 | Context summary bit |

## Verification
A corrupted register or control image appears on the read ports or on `csr_rdata` in the first cycle in which that index or alias is addressed. The random stream re-reads both of them constantly, so such a fault is seen within a few cycles. A missed or spurious dirty marking shows on `ctx_upd` in the same cycle as the write and on `ctx_fs`/`ctx_sd` one cycle later. A wrong alias decode shows at once, either on the read view or on the stored image after the next edge.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam int CSR_AW  = 12;
    localparam int FLAG_W  = 5;
    localparam int RMODE_W = 3;
    localparam int CTL_W   = FLAG_W + RMODE_W;

    localparam logic [CSR_AW-1:0] ADDR_FLAGS = 12'h001;
    localparam logic [CSR_AW-1:0] ADDR_RMODE = 12'h002;
    localparam logic [CSR_AW-1:0] ADDR_FULL  = 12'h003;

    typedef struct packed {
        logic [RMODE_W-1:0] rmode;
        logic [FLAG_W-1:0]  flags;
    } fctl_t;

    typedef enum logic [1:0] {
        XS_OFF   = 2'b00,
        XS_INIT  = 2'b01,
        XS_CLEAN = 2'b10,
        XS_DIRTY = 2'b11
    } xstat_e;

    typedef enum logic [1:0] {
        VIEW_NONE,
        VIEW_FLAGS,
        VIEW_RMODE,
        VIEW_FULL
    } view_e;

    function automatic view_e decode_view(input logic [CSR_AW-1:0] a);
        view_e v;
        case (a)
            ADDR_FLAGS: v = VIEW_FLAGS;
            ADDR_RMODE: v = VIEW_RMODE;
            ADDR_FULL:  v = VIEW_FULL;
            default:    v = VIEW_NONE;
        endcase
        return v;
    endfunction

    function automatic logic [CTL_W-1:0] view_read(input view_e v, input fctl_t c);
        logic [CTL_W-1:0] r;
        r = '0;
        case (v)
            VIEW_FLAGS: r[FLAG_W-1:0]  = c.flags;
            VIEW_RMODE: r[RMODE_W-1:0] = c.rmode;
            VIEW_FULL:  r              = c;
            default:    r              = '0;
        endcase
        return r;
    endfunction

    function automatic fctl_t view_merge(input view_e v, input fctl_t c,
                                         input logic [CTL_W-1:0] w);
        fctl_t n;
        n = c;
        case (v)
            VIEW_FLAGS: n.flags = w[FLAG_W-1:0];
            VIEW_RMODE: n.rmode = w[RMODE_W-1:0];
            VIEW_FULL:  n       = fctl_t'(w);
            default:    n       = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fpst_regfile.sv
module fpst_regfile #(
    parameter int NREG  = 32,
    parameter int FLEN  = 64,
    parameter int NRD   = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [FLEN-1:0]            wdata,
    input  logic [NRD-1:0][IDX_W-1:0]  ridx,
    output logic [NRD-1:0][FLEN-1:0]   rdata
);

    logic [FLEN-1:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                bank[i] <= wdata;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rdata[p] = bank[ridx[p]];
        end
    end

endmodule

// File: rtl/fpst_csr.sv
module fpst_csr
    import fpst_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] addr,
    input  logic              we,
    input  logic [XLEN-1:0]   wdata,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    output logic [XLEN-1:0]   rdata,
    output logic              hit,
    output logic              wr_fire,
    output logic [XLEN-1:0]   result
);

    localparam int PAD_W = XLEN - CTL_W;

    fctl_t ctl_q;
    fctl_t ctl_merged;
    fctl_t ctl_d;
    view_e view;
    logic  unused_wr_hi;

    assign unused_wr_hi = ^wdata[XLEN-1:CTL_W];

    always_comb begin
        view       = decode_view(addr);
        hit        = (view != VIEW_NONE);
        wr_fire    = we && hit;
        ctl_merged = wr_fire ? view_merge(view, ctl_q, wdata[CTL_W-1:0]) : ctl_q;
        ctl_d      = ctl_merged;
        if (acc_valid) begin
            ctl_d.flags = ctl_merged.flags | acc_flags;
        end
        rdata  = {{PAD_W{1'b0}}, view_read(view, ctl_q)};
        result = (wr_fire && (view == VIEW_FULL)) ? {{PAD_W{1'b0}}, ctl_d} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/fpst_dirty.sv
module fpst_dirty
    import fpst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mark_rf,
    input  logic       mark_csr,
    input  logic       mark_acc,
    output logic       upd,
    output logic [1:0] fs,
    output logic       sd
);

    xstat_e fs_q;
    logic   sd_q;

    assign upd = mark_rf | mark_csr | mark_acc;
    assign fs  = fs_q;
    assign sd  = sd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= XS_OFF;
            sd_q <= 1'b0;
        end else if (upd) begin
            fs_q <= XS_DIRTY;
            sd_q <= 1'b1;
        end
    end

endmodule

// File: rtl/fp_state_unit.sv
module fp_state_unit
    import fpst_pkg::*;
#(
    parameter int NREG = 32,
    parameter int FLEN = 64,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rf_ra_idx,
    output logic [FLEN-1:0]   rf_ra_data,
    input  logic [IDX_W-1:0]  rf_rb_idx,
    output logic [FLEN-1:0]   rf_rb_data,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_wr_idx,
    input  logic [FLEN-1:0]   rf_wr_data,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    output logic [XLEN-1:0]   csr_wr_result,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    output logic              ctx_upd,
    output logic [1:0]        ctx_fs,
    output logic              ctx_sd
);

    localparam int NRD = 2;

    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0][FLEN-1:0]  rd_data;
    logic                      csr_fire;

    assign rd_idx[0]  = rf_ra_idx;
    assign rd_idx[1]  = rf_rb_idx;
    assign rf_ra_data = rd_data[0];
    assign rf_rb_data = rd_data[1];

    fpst_regfile #(
        .NREG (NREG),
        .FLEN (FLEN),
        .NRD  (NRD)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .widx  (rf_wr_idx),
        .wdata (rf_wr_data),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    fpst_csr #(
        .XLEN (XLEN)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .addr      (csr_addr),
        .we        (csr_we),
        .wdata     (csr_wdata),
        .acc_valid (acc_valid),
        .acc_flags (acc_flags),
        .rdata     (csr_rdata),
        .hit       (csr_hit),
        .wr_fire   (csr_fire),
        .result    (csr_wr_result)
    );

    fpst_dirty u_dirty (
        .clk      (clk),
        .rst      (rst),
        .mark_rf  (rf_we),
        .mark_csr (csr_fire),
        .mark_acc (acc_valid),
        .upd      (ctx_upd),
        .fs       (ctx_fs),
        .sd       (ctx_sd)
    );

endmodule

// File: rtl/fp_state_unit_chk.sv
module fp_state_unit_chk
    import fpst_pkg::*;
#(
    parameter int NREG = 32,
    parameter int FLEN = 64,
    parameter int XLEN = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  rf_ra_idx,
    input logic [FLEN-1:0]   rf_ra_data,
    input logic [IDX_W-1:0]  rf_rb_idx,
    input logic [FLEN-1:0]   rf_rb_data,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_wr_idx,
    input logic [FLEN-1:0]   rf_wr_data,
    input logic [CSR_AW-1:0] csr_addr,
    input logic              csr_we,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              csr_hit,
    input logic [XLEN-1:0]   csr_wr_result,
    input logic              acc_valid,
    input logic [FLAG_W-1:0] acc_flags,
    input logic              ctx_upd,
    input logic [1:0]        ctx_fs,
    input logic              ctx_sd
);

    // R1: status leaves reset clean
    a_r1_status_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctx_fs == 2'b00) && !ctx_sd);

    // R3: register write leads to Dirty on the next cycle
    a_r3_rf_write_dirty: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> (ctx_fs == 2'b11) && ctx_sd);

    // R3: Dirty is sticky
    a_r3_status_sticky: assert property (@(posedge clk) disable iff (rst)
        ctx_sd |=> ctx_sd && (ctx_fs == 2'b11));

    // R4: bits above the image always read zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[XLEN-1:8] == '0);

    // R4: unmapped addresses read zero
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !csr_hit |-> (csr_rdata == '0));

    // R7: an aliased CSR write raises the strobe
    a_r7_csr_write_upd: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_hit) |-> ctx_upd);

    // R7: no state change, no strobe
    a_r7_quiet_no_upd: assert property (@(posedge clk) disable iff (rst)
        !(rf_we || (csr_we && csr_hit) || acc_valid) |-> !ctx_upd);

    // R8: result is zero outside full-alias writes
    a_r8_result_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(csr_we && (csr_addr == 12'h003)) |-> (csr_wr_result == '0));

    // R9: accrual raises the strobe
    a_r9_acc_upd: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ctx_upd);

endmodule

bind fp_state_unit fp_state_unit_chk #(
    .NREG (NREG),
    .FLEN (FLEN),
    .XLEN (XLEN)
) u_chk (.*);

// File: tb/fp_state_unit_test.sv
module fp_state_unit_test;

    localparam int CLK_P = 10;
    localparam int NREG  = 32;
    localparam int FLEN  = 64;
    localparam int XLEN  = 64;
    localparam int NRAND = 3000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [4:0]       rf_ra_idx = '0, rf_rb_idx = '0, rf_wr_idx = '0;
    logic [FLEN-1:0]  rf_ra_data, rf_rb_data, rf_wr_data = '0;
    logic             rf_we = 1'b0;
    logic [11:0]      csr_addr = '0;
    logic             csr_we = 1'b0;
    logic [XLEN-1:0]  csr_wdata = '0, csr_rdata, csr_wr_result;
    logic             csr_hit;
    logic             acc_valid = 1'b0;
    logic [4:0]       acc_flags = '0;
    logic             ctx_upd, ctx_sd;
    logic [1:0]       ctx_fs;

    int n_chk = 0;
    int n_bad = 0;

    logic [FLEN-1:0] m_reg [NREG];
    logic [7:0]      m_ctl;
    logic            m_dirty;

    always #(CLK_P/2) clk = ~clk;

    fp_state_unit #(.NREG(NREG), .FLEN(FLEN), .XLEN(XLEN)) uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_view(input logic [11:0] a, input logic [7:0] c);
        case (a)
            12'h001: return {59'd0, c[4:0]};
            12'h002: return {61'd0, c[7:5]};
            12'h003: return {56'd0, c};
            default: return 64'd0;
        endcase
    endfunction

    function automatic bit is_alias(input logic [11:0] a);
        return (a == 12'h001) || (a == 12'h002) || (a == 12'h003);
    endfunction

    function automatic logic [7:0] exp_next(input logic [11:0] a, input logic we,
            input logic [63:0] wd, input logic av, input logic [4:0] af,
            input logic [7:0] c);
        logic [7:0] n;
        n = c;
        if (we) begin
            case (a)
                12'h001: n[4:0] = wd[4:0];
                12'h002: n[7:5] = wd[2:0];
                12'h003: n      = wd[7:0];
                default: n      = c;
            endcase
        end
        if (av) n[4:0] = n[4:0] | af;
        return n;
    endfunction

    // inputs are already set after a falling edge; check, clock, update model
    task automatic step();
        logic [7:0] nx;
        logic       up;
        #1;
        nx = exp_next(csr_addr, csr_we, csr_wdata, acc_valid, acc_flags, m_ctl);
        up = rf_we || (csr_we && is_alias(csr_addr)) || acc_valid;
        check(rf_ra_data == m_reg[rf_ra_idx], "R2 port A", rf_ra_data, m_reg[rf_ra_idx]);
        check(rf_rb_data == m_reg[rf_rb_idx], "R2 port B", rf_rb_data, m_reg[rf_rb_idx]);
        check(csr_rdata == exp_view(csr_addr, m_ctl), "R4 view", csr_rdata,
              exp_view(csr_addr, m_ctl));
        check(csr_hit == is_alias(csr_addr), "R4 hit", 64'(csr_hit), 64'(is_alias(csr_addr)));
        check(csr_wr_result == ((csr_we && csr_addr == 12'h003) ? {56'd0, nx} : 64'd0),
              "R8 result", csr_wr_result,
              (csr_we && csr_addr == 12'h003) ? {56'd0, nx} : 64'd0);
        check(ctx_upd == up, "R10 upd strobe", 64'(ctx_upd), 64'(up));
        check(ctx_fs == {2{m_dirty}} && ctx_sd == m_dirty, "R3 status",
              {61'd0, ctx_fs, ctx_sd}, {61'd0, m_dirty, m_dirty, m_dirty});
        @(posedge clk);
        if (rf_we) m_reg[rf_wr_idx] = rf_wr_data;
        m_ctl = nx;
        if (up) m_dirty = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        rf_we = 0; csr_we = 0; acc_valid = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        foreach (m_reg[i]) m_reg[i] = '0;
        m_ctl = '0;
        m_dirty = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register and the image are zero after reset
        for (int i = 0; i < NREG; i++) begin
            rf_ra_idx = 5'(i); rf_rb_idx = 5'(NREG - 1 - i);
            csr_addr = 12'h003;
            #1;
            check(rf_ra_data == '0 && rf_rb_data == '0, "R1 reg zero", rf_ra_data, 64'd0);
            check(csr_rdata == '0 && ctx_fs == 2'b00 && !ctx_sd, "R1 csr/status zero",
                  csr_rdata, 64'd0);
            @(negedge clk);
        end

        // R7: write to non-aliased addresses changes nothing and stays clean
        csr_we = 1; csr_wdata = '1; csr_addr = 12'h004; step();
        csr_addr = 12'h000; step();
        idle(); csr_addr = 12'h003; #1;
        check(csr_rdata == 64'd0 && ctx_fs == 2'b00, "R7 unmapped write ignored",
              csr_rdata, 64'd0);
        step();

        // R5/R6: rounding mode 7 through its alias, flags untouched; upper bits ignored
        csr_we = 1; csr_addr = 12'h002; csr_wdata = 64'hFFFF_FFFF_FFFF_FFF7; step();
        idle(); csr_addr = 12'h003; #1;
        check(csr_rdata == 64'h0000_00E0, "R6 rmode 7 kept", csr_rdata, 64'hE0);
        check(ctx_fs == 2'b11 && ctx_sd, "R7 csr write dirty", {62'd0, ctx_fs}, 64'd3);
        step();
        for (int rm = 5; rm < 8; rm++) begin
            csr_we = 1; csr_addr = 12'h002; csr_wdata = 64'(rm); step();
            idle(); csr_addr = 12'h002; #1;
            check(csr_rdata == 64'(rm), "R6 rmode readback", csr_rdata, 64'(rm));
            step();
        end

        // R5: flags alias writes only flags
        csr_we = 1; csr_addr = 12'h001; csr_wdata = 64'hFFFF_FF15; step();
        idle(); csr_addr = 12'h003; #1;
        check(csr_rdata == 64'hF5, "R5 flags only", csr_rdata, 64'hF5);
        step();

        // R9: accrue onto a same-cycle full write
        csr_we = 1; csr_addr = 12'h003; csr_wdata = 64'hA1; acc_valid = 1; acc_flags = 5'h06;
        #1;
        check(csr_wr_result == 64'hA7, "R9 acc with full write", csr_wr_result, 64'hA7);
        step();
        idle(); csr_addr = 12'h001; #1;
        check(csr_rdata == 64'h07, "R9 flags ORed", csr_rdata, 64'h07);
        step();

        // R2: same-cycle write and read of index 5, then R10 combined writes
        rf_we = 1; rf_wr_idx = 5; rf_wr_data = 64'hDEAD_BEEF_0123_4567;
        rf_ra_idx = 5; rf_rb_idx = 5;
        csr_we = 1; csr_addr = 12'h003; csr_wdata = 64'h3C;
        step();
        idle(); #1;
        check(rf_ra_data == 64'hDEAD_BEEF_0123_4567, "R2 new value next cycle",
              rf_ra_data, 64'hDEAD_BEEF_0123_4567);
        check(csr_rdata == 64'h3C, "R10 both writes landed", csr_rdata, 64'h3C);
        step();

        // random mix
        for (int k = 0; k < NRAND; k++) begin
            int sel;
            rf_ra_idx  = 5'($urandom);
            rf_rb_idx  = ($urandom_range(3) == 0) ? rf_ra_idx : 5'($urandom);
            rf_we      = ($urandom_range(9) < 4);
            rf_wr_idx  = ($urandom_range(3) == 0) ? rf_ra_idx : 5'($urandom);
            rf_wr_data = {$urandom, $urandom};
            sel = $urandom_range(5);
            csr_addr   = (sel < 5) ? 12'(sel) : 12'($urandom);
            csr_we     = ($urandom_range(9) < 4);
            csr_wdata  = {$urandom, $urandom};
            acc_valid  = ($urandom_range(3) == 0);
            acc_flags  = 5'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule